// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block is the issue interlock for a five-stage in-order pipeline. Stages are numbered 1 (fetch) to 5 (register write-back), one clock each. In every cycle it looks at the instruction waiting in stage 2, at the writers held in stages 3 to 5, and at whether stage 4 is using the single-ported main memory for data. From these it decides whether fetch may run, whether stage 2 must hold, and where a bubble (an empty slot with its valid bit cleared) goes. There is no forwarding path, so a true (read-after-write) dependency is resolved only by waiting. Under strict in-order issue, write-after-read and write-after-write ordering cannot go wrong, so the block checks neither.

A register result is written at the end of stage 5, and operands are read at the start of stage 2. With the default register-file option (`WB_SAME_CYCLE=1`), a stage-5 writer is seen by a stage-2 read in the same cycle. A dependent instruction that directly follows its producer then waits two clocks. With `WB_SAME_CYCLE=0`, stage 5 also interlocks. A data access in stage 4 takes the memory port, so fetch idles for that cycle and a bubble enters stage 2. A saturating counter totals every cycle in which fetch is idle. All control outputs are combinational in the same cycle. There is no streaming data at this block's edge, so all pins are plain level signals without handshake.

Top module: `hz_stall_ctrl`

## Requirements
- R1: When stage 2 is valid and a used source register (nonzero) equals the destination of a valid writing instruction in stage 3 or stage 4, then `id_hold`=1, `ex_bubble`=1 and `fetch_en`=0 in the same cycle.
- R2: A valid writer in stage 5 with a matching register causes no stall when `WB_SAME_CYCLE`=1, and causes the R1 stall when `WB_SAME_CYCLE`=0.
- R3: No dependency arises from register 0, from a source whose use bit is 0, from a stage whose valid bit is 0, from a stage whose write bit is 0, or when stage 2 itself is invalid.
- R4: In a cycle-level pipeline, an instruction that reads the result of the instruction directly ahead of it costs exactly two stall cycles (default option), and every instruction still reaches stage 5.
- R5: When stage 4 is valid with its data-access flag set and there is no register hazard, then `fetch_en`=0, `id_bubble`=1, `id_hold`=0 and `ex_bubble`=0. A stage-4 access with the valid bit at 0 has no effect.
- R6: When a register hazard and a memory conflict occur in the same cycle, the register-hazard outputs apply (`id_hold`=1, `ex_bubble`=1, `id_bubble`=0, `fetch_en`=0), and the counter advances by one only.
- R7: `stall_cnt` increases by one on each clock in which `fetch_en` is 0. It stays unchanged otherwise and stops at its maximum value of all ones.
- R8: While `rst_n` is 0, `stall_cnt` is 0, even with a conflict present.
- R9: With no hazard, `fetch_en`=1 and `id_hold`, `ex_bubble` and `id_bubble` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the counter |
| id_valid | input | 1 | Stage 2 holds an instruction |
| id_src_a | input | REG_W | First source register of stage 2 |
| id_use_a | input | 1 | First source is read |
| id_src_b | input | REG_W | Second source register of stage 2 |
| id_use_b | input | 1 | Second source is read |
| ex_valid | input | 1 | Stage 3 holds an instruction |
| ex_wr | input | 1 | Stage 3 writes a register |
| ex_rd | input | REG_W | Stage 3 destination register |
| mem_valid | input | 1 | Stage 4 holds an instruction |
| mem_wr | input | 1 | Stage 4 writes a register |
| mem_rd | input | REG_W | Stage 4 destination register |
| mem_data_acc | input | 1 | Stage 4 reads or writes main memory |
| wb_valid | input | 1 | Stage 5 holds an instruction |
| wb_wr | input | 1 | Stage 5 writes a register |
| wb_rd | input | REG_W | Stage 5 destination register |
| fetch_en | output | 1 | Fetch may use the memory port and advance |
| id_hold | output | 1 | Stage 2 and fetch keep their contents |
| ex_bubble | output | 1 | Load an invalid slot into stage 3 |
| id_bubble | output | 1 | Load an invalid slot into stage 2 |
| stall_cnt | output | CNT_W | Saturating count of fetch-idle cycles |

## Verification
The vector table places each source/destination match in turn in stage 3, stage 4 and stage 5. This separates a true interlock from a write-back that is already visible to the read. Near-miss patterns (register 0, cleared use, valid or write bit, invalid stage 2) show that each qualifier gates the match on its own. A memory access with and without its valid bit, and combined with a register hazard, separates fetch idling from a stage-2 hold and shows the counter does not count one cycle twice. Short programs run through a bench model of the stages then confirm the two-cycle cost of a back-to-back dependency, the one-cycle cost of a data access, full retirement of every instruction, and counter saturation with the stage-5 interlock option.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    HZ_NONE   = 2'd0,
    HZ_STRUCT = 2'd1,
    HZ_RAW    = 2'd2
  } hz_kind_e;

  function automatic hz_kind_e hz_pick(input logic raw, input logic conflict);
    if (raw)           return HZ_RAW;
    else if (conflict) return HZ_STRUCT;
    else               return HZ_NONE;
  endfunction
endpackage

// File: rtl/hz_raw_detect.sv
module hz_raw_detect #(
  parameter int REG_W         = 5,
  parameter bit WB_SAME_CYCLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] src_a,
  input  logic             use_a,
  input  logic [REG_W-1:0] src_b,
  input  logic             use_b,
  input  logic [2:0]       wr_valid,
  input  logic [2:0]       wr_en,
  input  logic [REG_W-1:0] wr_rd [3],
  output logic             raw
);
  localparam int N_CHECK = WB_SAME_CYCLE ? 2 : 3;

  logic need_a, need_b;
  logic [N_CHECK-1:0] hit;

  assign need_a = id_valid && use_a && (src_a != '0);
  assign need_b = id_valid && use_b && (src_b != '0);

  for (genvar g = 0; g < N_CHECK; g++) begin : g_wr
    logic live;
    assign live   = wr_valid[g] && wr_en[g];
    assign hit[g] = live && ((need_a && (src_a == wr_rd[g])) ||
                             (need_b && (src_b == wr_rd[g])));
  end

  assign raw = |hit;

  p_zero_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0 && src_b == '0) |-> !raw);
  p_idle_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_a && !use_b) |-> !raw);
endmodule

// File: rtl/hz_mem_conflict.sv
module hz_mem_conflict (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_valid,
  input  logic mem_data_acc,
  output logic conflict
);
  assign conflict = mem_valid && mem_data_acc;

  p_invalid_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !conflict);
endmodule

// File: rtl/hz_issue_arb.sv
module hz_issue_arb
  import hz_pkg::*;
(
  input  logic raw,
  input  logic conflict,
  output logic fetch_en,
  output logic id_hold,
  output logic ex_bubble,
  output logic id_bubble
);
  hz_kind_e kind;

  always_comb begin
    kind      = hz_pick(raw, conflict);
    fetch_en  = 1'b1;
    id_hold   = 1'b0;
    ex_bubble = 1'b0;
    id_bubble = 1'b0;
    case (kind)
      HZ_RAW: begin
        fetch_en  = 1'b0;
        id_hold   = 1'b1;
        ex_bubble = 1'b1;
      end
      HZ_STRUCT: begin
        fetch_en  = 1'b0;
        id_bubble = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_stall_counter.sv
module hz_stall_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int REG_W         = 5,
  parameter int CNT_W         = 16,
  parameter bit WB_SAME_CYCLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_src_a,
  input  logic             id_use_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_use_b,
  input  logic             ex_valid,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_valid,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_data_acc,
  input  logic             wb_valid,
  input  logic             wb_wr,
  input  logic [REG_W-1:0] wb_rd,
  output logic             fetch_en,
  output logic             id_hold,
  output logic             ex_bubble,
  output logic             id_bubble,
  output logic [CNT_W-1:0] stall_cnt
);
  logic             raw, conflict;
  logic [2:0]       wr_valid, wr_en;
  logic [REG_W-1:0] wr_rd [3];

  assign wr_valid = {wb_valid, mem_valid, ex_valid};
  assign wr_en    = {wb_wr, mem_wr, ex_wr};
  assign wr_rd[0] = ex_rd;
  assign wr_rd[1] = mem_rd;
  assign wr_rd[2] = wb_rd;

  hz_raw_detect #(.REG_W(REG_W), .WB_SAME_CYCLE(WB_SAME_CYCLE)) u_raw (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
    .src_a(id_src_a), .use_a(id_use_a), .src_b(id_src_b), .use_b(id_use_b),
    .wr_valid(wr_valid), .wr_en(wr_en), .wr_rd(wr_rd), .raw(raw)
  );

  hz_mem_conflict u_mem (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid),
    .mem_data_acc(mem_data_acc), .conflict(conflict)
  );

  hz_issue_arb u_arb (
    .raw(raw), .conflict(conflict), .fetch_en(fetch_en),
    .id_hold(id_hold), .ex_bubble(ex_bubble), .id_bubble(id_bubble)
  );

  hz_stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(!fetch_en), .cnt(stall_cnt)
  );

  p_hold_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    id_hold |-> (ex_bubble && !fetch_en && !id_bubble));
  p_raw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && conflict) |-> (id_hold && !id_bubble));
  p_struct_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !raw) |-> (!fetch_en && id_bubble && !id_hold));
  p_free_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw && !conflict) |-> (fetch_en && !id_hold && !ex_bubble && !id_bubble));
endmodule

// File: tb/hz_stall_ctrl_bench.sv
`timescale 1ns/1ps
module hz_stall_ctrl_bench;
  localparam int RW = 5;
  localparam int VW = 39;
  localparam int NV = 13;

  // {id_v, sa, ua, sb, ub, ex_v, ex_w, ex_rd, mem_v, mem_w, mem_rd, mem_acc,
  //  wb_v, wb_w, wb_rd, exp_fetch_en, exp_id_hold, exp_ex_bubble, exp_id_bubble}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,5'd0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b1000}, // R9 idle
    {1'b1,5'd3,1'b1,5'd9,1'b1, 1'b1,1'b1,5'd3, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b0110}, // R1 stage3 on a
    {1'b1,5'd1,1'b1,5'd7,1'b1, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd7,1'b0, 1'b0,1'b0,5'd0, 4'b0110}, // R1 stage4 on b
    {1'b1,5'd5,1'b1,5'd6,1'b1, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd5, 4'b1000}, // R2 stage5 free
    {1'b1,5'd0,1'b1,5'd0,1'b1, 1'b1,1'b1,5'd0, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b1000}, // R3 reg0
    {1'b1,5'd3,1'b1,5'd0,1'b0, 1'b0,1'b1,5'd3, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b1000}, // R3 stage invalid
    {1'b1,5'd3,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd3, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b1000}, // R3 use cleared
    {1'b1,5'd3,1'b1,5'd0,1'b0, 1'b1,1'b0,5'd3, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b1000}, // R3 no write
    {1'b0,5'd3,1'b1,5'd3,1'b1, 1'b1,1'b1,5'd3, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 4'b1000}, // R3 id invalid
    {1'b1,5'd2,1'b1,5'd0,1'b0, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd0,1'b1, 1'b0,1'b0,5'd0, 4'b0001}, // R5 memory port
    {1'b1,5'd2,1'b1,5'd0,1'b0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0,1'b1, 1'b0,1'b0,5'd0, 4'b1000}, // R5 invalid access
    {1'b1,5'd2,1'b1,5'd0,1'b0, 1'b1,1'b1,5'd2, 1'b1,1'b0,5'd0,1'b1, 1'b0,1'b0,5'd0, 4'b0110}, // R6 both
    {1'b1,5'd1,1'b0,5'd4,1'b1, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd4,1'b1, 1'b0,1'b0,5'd0, 4'b0110}  // R6 same stage
  };

  typedef struct packed {
    logic v; logic wr; logic [RW-1:0] rd;
    logic [RW-1:0] sa; logic ua; logic [RW-1:0] sb; logic ub; logic mem;
  } instr_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid, id_use_a, id_use_b, ex_valid, ex_wr, mem_valid, mem_wr, mem_data_acc, wb_valid, wb_wr;
  logic [RW-1:0] id_src_a, id_src_b, ex_rd, mem_rd, wb_rd;
  logic fetch_en, id_hold, ex_bubble, id_bubble;
  logic a_fetch_en, a_id_hold, a_ex_bubble, a_id_bubble;
  logic [15:0] stall_cnt;
  logic [1:0]  a_stall_cnt;
  int total = 0, bad = 0;
  instr_t prog [4];

  always #2 clk = ~clk;

  hz_stall_ctrl u_hz_stall_ctrl (
    .clk, .rst_n, .id_valid, .id_src_a, .id_use_a, .id_src_b, .id_use_b,
    .ex_valid, .ex_wr, .ex_rd, .mem_valid, .mem_wr, .mem_rd, .mem_data_acc,
    .wb_valid, .wb_wr, .wb_rd, .fetch_en, .id_hold, .ex_bubble, .id_bubble, .stall_cnt
  );

  hz_stall_ctrl #(.CNT_W(2), .WB_SAME_CYCLE(1'b0)) u_hz_stall_ctrl_alt (
    .clk, .rst_n, .id_valid, .id_src_a, .id_use_a, .id_src_b, .id_use_b,
    .ex_valid, .ex_wr, .ex_rd, .mem_valid, .mem_wr, .mem_rd, .mem_data_acc,
    .wb_valid, .wb_wr, .wb_rd, .fetch_en(a_fetch_en), .id_hold(a_id_hold),
    .ex_bubble(a_ex_bubble), .id_bubble(a_id_bubble), .stall_cnt(a_stall_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    {id_valid, id_use_a, id_use_b, ex_valid, ex_wr, mem_valid, mem_wr, mem_data_acc, wb_valid, wb_wr} = '0;
    {id_src_a, id_src_b, ex_rd, mem_rd, wb_rd} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_stages(input instr_t p2, input instr_t p3, input instr_t p4, input instr_t p5);
    id_valid = p2.v; id_src_a = p2.sa; id_use_a = p2.ua; id_src_b = p2.sb; id_use_b = p2.ub;
    ex_valid = p3.v; ex_wr = p3.wr; ex_rd = p3.rd;
    mem_valid = p4.v; mem_wr = p4.wr; mem_rd = p4.rd; mem_data_acc = p4.mem;
    wb_valid = p5.v; wb_wr = p5.wr; wb_rd = p5.rd;
  endtask

  task automatic run_prog(input int len, input int exp_stall, input string tag);
    instr_t p2, p3, p4, p5;
    int pc, retired, stalls;
    logic s_fe, s_hold;
    logic [15:0] c0;
    p2 = '0; p3 = '0; p4 = '0; p5 = '0; pc = 0; retired = 0; stalls = 0;
    c0 = stall_cnt;
    for (int cyc = 0; cyc < 14; cyc++) begin
      @(negedge clk);
      drive_stages(p2, p3, p4, p5);
      #1;
      s_fe = fetch_en; s_hold = id_hold;
      if (!s_fe) stalls++;
      if (p5.v) retired++;
      @(posedge clk);
      p5 = p4; p4 = p3;
      p3 = s_hold ? instr_t'('0) : p2;
      if (!s_hold) begin
        if (s_fe && pc < len) begin p2 = prog[pc]; pc++; end
        else p2 = '0;
      end
    end
    @(negedge clk);
    clear_in();
    #1;
    check({tag, " stall cycles"}, stalls, exp_stall);
    check({tag, " retired"}, retired, len);
    check({tag, " counter delta"}, 32'(stall_cnt - c0), exp_stall);
  endtask

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    bad++; total++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    logic [15:0] exp_cnt;
    clear_in();
    mem_valid = 1'b1; mem_data_acc = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 count held in reset", stall_cnt, 0);
    clear_in();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 idle fetch_en", fetch_en, 1);

    exp_cnt = 0;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      {id_valid, id_src_a, id_use_a, id_src_b, id_use_b, ex_valid, ex_wr, ex_rd,
       mem_valid, mem_wr, mem_rd, mem_data_acc, wb_valid, wb_wr, wb_rd} = v[VW-1:4];
      #1;
      check($sformatf("R1/R3/R5/R6/R9 vector %0d outputs", i),
            {fetch_en, id_hold, ex_bubble, id_bubble}, v[3:0]);
      if (!v[3]) exp_cnt++;
      @(posedge clk);
      #1;
      check($sformatf("R7 vector %0d counter", i), stall_cnt, exp_cnt);
    end

    // R2: stage-5 match stalls only with the interlock option
    @(negedge clk);
    clear_in();
    id_valid = 1'b1; id_src_a = 5'd5; id_use_a = 1'b1; wb_valid = 1'b1; wb_wr = 1'b1; wb_rd = 5'd5;
    #1;
    check("R2 default stage5 no hold", id_hold, 0);
    check("R2 option stage5 hold", {a_id_hold, a_ex_bubble, a_fetch_en}, 3'b110);

    // R4: back-to-back dependency
    @(negedge clk); clear_in();
    do_reset();
    prog[0] = '{v:1'b1, wr:1'b1, rd:5'd1, sa:5'd2, ua:1'b1, sb:5'd3, ub:1'b1, mem:1'b0};
    prog[1] = '{v:1'b1, wr:1'b1, rd:5'd4, sa:5'd1, ua:1'b1, sb:5'd5, ub:1'b1, mem:1'b0};
    run_prog(2, 2, "R4 dependent pair");

    // R5: one data access idles fetch once
    prog[0] = '{v:1'b1, wr:1'b1, rd:5'd6, sa:5'd0, ua:1'b0, sb:5'd0, ub:1'b0, mem:1'b1};
    prog[1] = '{v:1'b1, wr:1'b1, rd:5'd7, sa:5'd8, ua:1'b1, sb:5'd0, ub:1'b0, mem:1'b0};
    prog[2] = '{v:1'b1, wr:1'b1, rd:5'd9, sa:5'd10, ua:1'b1, sb:5'd0, ub:1'b0, mem:1'b0};
    prog[3] = '{v:1'b1, wr:1'b1, rd:5'd11, sa:5'd12, ua:1'b1, sb:5'd0, ub:1'b0, mem:1'b0};
    run_prog(4, 1, "R5 data access program");

    // R3: independent program, no stall
    prog[0] = '{v:1'b1, wr:1'b1, rd:5'd0, sa:5'd2, ua:1'b1, sb:5'd0, ub:1'b0, mem:1'b0};
    prog[1] = '{v:1'b1, wr:1'b1, rd:5'd4, sa:5'd0, ua:1'b1, sb:5'd0, ub:1'b1, mem:1'b0};
    prog[2] = '{v:1'b1, wr:1'b0, rd:5'd0, sa:5'd4, ua:1'b0, sb:5'd0, ub:1'b0, mem:1'b0};
    run_prog(3, 0, "R3 independent program");

    // R7: saturation on the two-bit counter
    do_reset();
    mem_valid = 1'b1; mem_data_acc = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    clear_in();
    #1;
    check("R7 saturated small counter", a_stall_cnt, 3);
    check("R7 wide counter six cycles", stall_cnt, 6);
    @(posedge clk); #1;
    check("R7 no increment when fetching", stall_cnt, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule